// File: doc/BRIEF.md
# Glitch-free base clock selector

This block produces the base clock and the bus clock of a chip from one of two running sources: a crystal-derived reference clock and the VCO output of a PLL. The analog PLL and its lock detection sit outside the block. The block gets the VCO clock and a lock flag as inputs. It gives the PLL its settings from an 8-bit configuration register. The register holds a multiplier field and a range field, and the block decodes both.

A source change never produces a shortened pulse on the output. The old source is gated off on its own falling edge. The new source is gated on only after that has been seen across two synchronizer flops, and it is gated on at its own falling edge. During the exchange the selected clock sits low. The selected clock is halved to make the base clock and halved again to make the bus clock. The bus clock therefore runs at one quarter of the chosen source.

A control state machine runs on the crystal clock and has four states. In SRC_XTAL the crystal drives the output. TO_VCO is entered from SRC_XTAL when a VCO request is valid. It waits until the VCO gate is seen to be open, then moves to SRC_VCO. SRC_VCO is the state in which the VCO drives the output. When the request stops being valid, SRC_VCO moves to TO_XTAL. TO_XTAL waits until the crystal gate is open again, then returns to SRC_XTAL. A request counts as valid only when the VCO is requested, the synchronized lock flag is high and the range field is non-zero.

Top module: `bclk_selector`

## Requirements
- R1: While reset is held and after it is released, the crystal is the source and `vco_active` is 0. The register reads zero, so `pll_range` is 0, `pll_en` is 0 and `pll_mult` is 1.
- R2: The register's multiplier field is bits [7:4] and its range field is bits [3:0]. `pll_range` shows the range field. A write takes effect on a rising crystal edge with `cfg_we` high, but only in state SRC_XTAL.
- R3: `pll_mult` equals the multiplier field, except that a field value of 0 gives `pll_mult` = 1.
- R4: `pll_en` is 1 exactly when the range field is non-zero. While `pll_en` is 0, a VCO request is ignored: `vco_active` stays 0 and the base clock keeps the crystal rate.
- R5: While `pll_lock` is low, a VCO request is ignored and the crystal stays the source.
- R6: With `sel_vco`, `pll_lock` and `pll_en` all high, the block moves to the VCO. `vco_active` becomes 1, the base clock period is twice the VCO period and the bus clock period is four times the VCO period.
- R7: With the crystal as source, the base clock period is twice the crystal period and the bus clock period is four times the crystal period.
- R8: The two source gates are never open together. No base clock high or low phase is shorter than one period of the faster source.
- R9: Writes made while `vco_active` is 1 are ignored, and the decoded outputs keep their values.
- R10: If `sel_vco` or `pll_lock` falls while the VCO is the source, the block returns to the crystal and `vco_active` becomes 0.
- R11: `vco_active` is 1 only while the crystal gate is closed and `pll_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crystal-derived reference clock; the register and state machine run on it |
| vclk | input | 1 | VCO clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | PLL lock flag, asynchronous, synchronized inside |
| sel_vco | input | 1 | Request to use the VCO as source, synchronous to xclk |
| cfg_we | input | 1 | Register write strobe, synchronous to xclk |
| cfg_wdata | input | 8 | Register write data: multiplier field [7:4], range field [3:0] |
| base_clk | output | 1 | Selected clock divided by two |
| bus_clk | output | 1 | Selected clock divided by four |
| vco_active | output | 1 | 1 when the VCO is the settled source |
| pll_mult | output | 4 | Decoded multiplier, never zero |
| pll_range | output | 4 | Range field as written |
| pll_en | output | 1 | PLL enable, high when the range field is non-zero |

## Verification
Some properties are checked on every crystal cycle. The two gates are never open at once. The status bit implies a closed crystal gate and an enabled PLL. The register does not change on a write made while the VCO is active. The decoded multiplier is never zero. Only the bench scenarios can show the rest: the measured base and bus clock periods on each source, the refusal of a request when lock or range is missing, the fall-back when lock drops, and the shortest pulse width seen across several switches in each direction.

// File: rtl/cgm_pkg.sv
`timescale 1ns/1ps
package cgm_pkg;
    localparam int FIELD_W = 4;
    localparam int CFG_W   = 2 * FIELD_W;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        TO_VCO   = 2'd1,
        SRC_VCO  = 2'd2,
        TO_XTAL  = 2'd3
    } src_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] mult;
        logic [FIELD_W-1:0] range;
        logic               en;
    } pll_cfg_t;
endpackage

// File: rtl/bclk_sync.sv
`timescale 1ns/1ps
module bclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/bclk_cfg_reg.sv
`timescale 1ns/1ps
module bclk_cfg_reg
    import cgm_pkg::*;
(
    input  logic             xclk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wr_ok,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output pll_cfg_t         dec
);
    logic [FIELD_W-1:0] n_fld;
    logic [FIELD_W-1:0] l_fld;

    always_ff @(posedge xclk or negedge rst_n) begin
        if (!rst_n)          cfg_q <= '0;
        else if (we && wr_ok) cfg_q <= wdata;
    end

    assign n_fld = cfg_q[CFG_W-1:FIELD_W];
    assign l_fld = cfg_q[FIELD_W-1:0];

    always_comb begin
        dec.mult  = (n_fld == '0) ? FIELD_W'(1) : n_fld;
        dec.range = l_fld;
        dec.en    = (l_fld != '0);
    end
endmodule

// File: rtl/bclk_src_fsm.sv
`timescale 1ns/1ps
module bclk_src_fsm
    import cgm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic xclk,
    input  logic rst_n,
    input  logic sel_vco,
    input  logic pll_lock,
    input  logic pll_en,
    input  logic v_en_x,
    input  logic x_en,
    output logic want_v,
    output logic vco_active,
    output logic wr_ok
);
    src_state_e state, state_nx;
    logic       lock_s;
    logic       sel_req;

    bclk_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk(xclk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
    );

    assign sel_req = sel_vco && lock_s && pll_en;

    always_ff @(posedge xclk or negedge rst_n) begin
        if (!rst_n) state <= SRC_XTAL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_XTAL: if (sel_req)  state_nx = TO_VCO;
            TO_VCO:   if (v_en_x)   state_nx = SRC_VCO;
            SRC_VCO:  if (!sel_req) state_nx = TO_XTAL;
            TO_XTAL:  if (x_en)     state_nx = SRC_XTAL;
            default:                state_nx = SRC_XTAL;
        endcase
    end

    always_comb begin
        want_v     = 1'b0;
        vco_active = 1'b0;
        wr_ok      = 1'b0;
        unique case (state)
            SRC_XTAL: wr_ok = 1'b1;
            TO_VCO:   want_v = 1'b1;
            SRC_VCO:  begin want_v = 1'b1; vco_active = 1'b1; end
            TO_XTAL:  ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bclk_gate_mux.sv
`timescale 1ns/1ps
module bclk_gate_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic xclk,
    input  logic vclk,
    input  logic rst_n,
    input  logic want_v,
    output logic x_en,
    output logic v_en,
    output logic v_en_x,
    output logic mux_clk
);
    logic want_v_v;
    logic x_en_v;

    bclk_sync #(.STAGES(SYNC_STAGES)) u_ven_to_x (
        .clk(xclk), .rst_n(rst_n), .d(v_en), .q(v_en_x)
    );
    bclk_sync #(.STAGES(SYNC_STAGES)) u_want_to_v (
        .clk(vclk), .rst_n(rst_n), .d(want_v), .q(want_v_v)
    );
    bclk_sync #(.STAGES(SYNC_STAGES)) u_xen_to_v (
        .clk(vclk), .rst_n(rst_n), .d(x_en), .q(x_en_v)
    );

    // Gates change only while their own clock is low.
    always_ff @(negedge xclk or negedge rst_n) begin
        if (!rst_n) x_en <= 1'b1;
        else        x_en <= !want_v && !v_en_x;
    end

    always_ff @(negedge vclk or negedge rst_n) begin
        if (!rst_n) v_en <= 1'b0;
        else        v_en <= want_v_v && !x_en_v;
    end

    assign mux_clk = (xclk && x_en) || (vclk && v_en);
endmodule

// File: rtl/bclk_divider.sv
`timescale 1ns/1ps
module bclk_divider #(
    parameter int STAGES = 2
) (
    input  logic              clk_in,
    input  logic              rst_n,
    output logic [STAGES-1:0] taps
);
    logic [STAGES:0] chain;

    assign chain[0] = clk_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_div
        logic t;
        always_ff @(posedge chain[i] or negedge rst_n) begin
            if (!rst_n) t <= 1'b0;
            else        t <= ~t;
        end
        assign chain[i+1] = t;
        assign taps[i]    = t;
    end
endmodule

// File: rtl/bclk_selector.sv
`timescale 1ns/1ps
module bclk_selector
    import cgm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             xclk,
    input  logic             vclk,
    input  logic             rst_n,
    input  logic             pll_lock,
    input  logic             sel_vco,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             base_clk,
    output logic             bus_clk,
    output logic             vco_active,
    output logic [FIELD_W-1:0] pll_mult,
    output logic [FIELD_W-1:0] pll_range,
    output logic             pll_en
);
    localparam int DIV_STAGES = 2;

    logic [CFG_W-1:0]      cfg_q;
    pll_cfg_t              dec;
    logic                  wr_ok;
    logic                  want_v;
    logic                  x_en;
    logic                  v_en;
    logic                  v_en_x;
    logic                  mux_clk;
    logic [DIV_STAGES-1:0] taps;

    bclk_cfg_reg u_cfg (
        .xclk(xclk), .rst_n(rst_n), .we(cfg_we), .wr_ok(wr_ok),
        .wdata(cfg_wdata), .cfg_q(cfg_q), .dec(dec)
    );

    bclk_src_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .xclk(xclk), .rst_n(rst_n), .sel_vco(sel_vco), .pll_lock(pll_lock),
        .pll_en(dec.en), .v_en_x(v_en_x), .x_en(x_en), .want_v(want_v),
        .vco_active(vco_active), .wr_ok(wr_ok)
    );

    bclk_gate_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .xclk(xclk), .vclk(vclk), .rst_n(rst_n), .want_v(want_v),
        .x_en(x_en), .v_en(v_en), .v_en_x(v_en_x), .mux_clk(mux_clk)
    );

    bclk_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk_in(mux_clk), .rst_n(rst_n), .taps(taps)
    );

    assign base_clk  = taps[0];
    assign bus_clk   = taps[1];
    assign pll_mult  = dec.mult;
    assign pll_range = dec.range;
    assign pll_en    = dec.en;
endmodule

// File: rtl/bclk_selector_chk.sv
`timescale 1ns/1ps
module bclk_selector_chk
    import cgm_pkg::*;
(
    input logic               xclk,
    input logic               rst_n,
    input logic               x_en,
    input logic               v_en,
    input logic               vco_active,
    input logic               pll_en,
    input logic               cfg_we,
    input logic [CFG_W-1:0]   cfg_q,
    input logic [FIELD_W-1:0] pll_mult
);
    // R8
    gates_exclusive_chk: assert property (@(posedge xclk) disable iff (!rst_n)
        $onehot0({x_en, v_en}));

    // R11
    status_gated_chk: assert property (@(posedge xclk) disable iff (!rst_n)
        vco_active |-> (!x_en && pll_en));

    // R9
    locked_write_chk: assert property (@(posedge xclk) disable iff (!rst_n)
        (cfg_we && vco_active) |=> $stable(cfg_q));

    // R3
    mult_nonzero_chk: assert property (@(posedge xclk) disable iff (!rst_n)
        pll_mult != '0);

    // R4
    range_gate_chk: assert property (@(posedge xclk) disable iff (!rst_n)
        !pll_en |-> !vco_active);
endmodule

bind bclk_selector bclk_selector_chk u_chk (
    .xclk(xclk), .rst_n(rst_n), .x_en(x_en), .v_en(v_en),
    .vco_active(vco_active), .pll_en(pll_en), .cfg_we(cfg_we),
    .cfg_q(cfg_q), .pll_mult(pll_mult)
);

// File: tb/tb_bclk_selector.sv
`timescale 1ns/1ps
module tb_bclk_selector;
    localparam real CLK_PERIOD = 20.0;
    localparam real VCO_PERIOD = 6.0;
    localparam int  NVEC = 5;
    // {wdata, expected mult, expected range, expected en}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h00, 4'd1,  4'd0, 1'b0},
        {8'h37, 4'd3,  4'd7, 1'b1},
        {8'h05, 4'd1,  4'd5, 1'b1},
        {8'hF1, 4'd15, 4'd1, 1'b1},
        {8'hA0, 4'd10, 4'd0, 1'b0}
    };

    logic xclk = 1'b0, vclk = 1'b0, rst_n = 1'b0;
    logic pll_lock = 1'b0, sel_vco = 1'b0, cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic base_clk, bus_clk, vco_active, pll_en;
    logic [3:0] pll_mult, pll_range;

    int  checks = 0, fails = 0;
    bit  done = 0;
    bit  mon_on = 0;
    real last_t = 0.0, min_w = 1.0e9, w;

    always #(CLK_PERIOD/2.0) xclk = ~xclk;
    always #(VCO_PERIOD/2.0) vclk = ~vclk;

    bclk_selector dut (
        .xclk(xclk), .vclk(vclk), .rst_n(rst_n), .pll_lock(pll_lock),
        .sel_vco(sel_vco), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .base_clk(base_clk), .bus_clk(bus_clk), .vco_active(vco_active),
        .pll_mult(pll_mult), .pll_range(pll_range), .pll_en(pll_en)
    );

    always @(base_clk) begin
        if (mon_on) begin
            w = $realtime - last_t;
            if (w < min_w) min_w = w;
        end
        last_t = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic wait_x(input int n);
        repeat (n) @(negedge xclk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge xclk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge xclk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic check_periods(input string req, input real src);
        real t0, pb, pu;
        @(posedge base_clk); t0 = $realtime;
        @(posedge base_clk); pb = $realtime - t0;
        @(posedge bus_clk);  t0 = $realtime;
        @(posedge bus_clk);  pu = $realtime - t0;
        check((pb > 2.0*src - 0.1) && (pb < 2.0*src + 0.1), req, "base period ps",
              int'(pb*1000.0), int'(2.0*src*1000.0));
        check((pu > 4.0*src - 0.1) && (pu < 4.0*src + 0.1), req, "bus period ps",
              int'(pu*1000.0), int'(4.0*src*1000.0));
        #1;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000.0);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        wait_x(3);
        // R1 during reset
        check_eq("R1", "vco_active in reset", vco_active, 0);
        check_eq("R1", "pll_en in reset", pll_en, 0);
        @(negedge xclk); rst_n = 1'b1;
        wait_x(2);
        check_eq("R1", "vco_active", vco_active, 0);
        check_eq("R1", "pll_mult", pll_mult, 1);
        check_eq("R1", "pll_range", pll_range, 0);
        check_eq("R1", "pll_en", pll_en, 0);
        // R7 crystal rate
        check_periods("R7", CLK_PERIOD);

        // R2 R3 R4 register decode table
        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] v;
            v = VEC[i];
            write_cfg(v[16:9]);
            check_eq("R3", "pll_mult", pll_mult, int'(v[8:5]));
            check_eq("R2", "pll_range", pll_range, int'(v[4:1]));
            check_eq("R4", "pll_en", pll_en, int'(v[0]));
        end

        // R4: range zero blocks the request
        pll_lock = 1'b1; sel_vco = 1'b1;
        wait_x(40);
        check_eq("R4", "vco_active with range 0", vco_active, 0);
        check_periods("R4", CLK_PERIOD);

        // R5: no lock blocks the request
        sel_vco = 1'b0; pll_lock = 1'b0;
        write_cfg(8'h37);
        sel_vco = 1'b1;
        wait_x(40);
        check_eq("R5", "vco_active without lock", vco_active, 0);

        // R6: switch to VCO
        min_w = 1.0e9; mon_on = 1;
        pll_lock = 1'b1;
        wait_x(40);
        check_eq("R6", "vco_active", vco_active, 1);
        check_periods("R6", VCO_PERIOD);

        // R9: write ignored while VCO active
        write_cfg(8'h00);
        check_eq("R9", "pll_range kept", pll_range, 7);
        check_eq("R9", "pll_mult kept", pll_mult, 3);
        check_eq("R9", "pll_en kept", pll_en, 1);

        // R10: request dropped
        sel_vco = 1'b0;
        wait_x(40);
        check_eq("R10", "vco_active after request drop", vco_active, 0);
        check_periods("R10", CLK_PERIOD);

        // R10: lock lost
        sel_vco = 1'b1;
        wait_x(40);
        check_eq("R6", "vco_active again", vco_active, 1);
        pll_lock = 1'b0;
        wait_x(40);
        check_eq("R10", "vco_active after lock loss", vco_active, 0);
        check_periods("R10", CLK_PERIOD);

        // R8: no runt phase across all switches
        mon_on = 0;
        check(min_w > VCO_PERIOD - 0.1, "R8", "min base phase ps",
              int'(min_w*1000.0), int'(VCO_PERIOD*1000.0));

        summary();
        $finish;
    end
endmodule